// File: doc/BRIEF.md
# Inertial Sensor Register Bank

This block is the register file on the slave side of a three-axis inertial sensor. A frame layer that has already decoded the serial protocol presents one register access per cycle: a read strobe or a write strobe, an address and a write byte. The bank returns the read byte combinationally in the same cycle. It applies every side effect of the access, such as latching, acknowledging or writing, on the following clock edge.

Each axis sample is a 13-bit two's-complement value and the temperature is a 16-bit value. Both are split over a low and a high byte. Reading a high byte copies the matching low byte into a shadow register, so a host that reads high before low always gets a coherent pair. Three fault flags are sticky until the host reads the interrupt status register. A keyed sequence of three writes triggers a one-clock software reset. Two summary flags feed straight back into the outgoing frame.

Top module: `sens_regbank`

## Requirements
- R1: After rst_n, address 0x00 reads REV_CODE, 0x1B reads ID_INIT, 0x01 reads CTRL_INIT (0x00) and 0x10 reads 0x00.
- R2: The control register (0x01) and the component ID register (0x1B) return on a read the last byte written to them.
- R3: Writes to read-only addresses (0x00, 0x02, 0x04 to 0x09, 0x0C, 0x0D, 0x10) change nothing that can be read.
- R4: Axis low bytes (X 0x04, Y 0x06, Z 0x08) carry sample bits 6..0 in bits 7..1, and bit 0 reads 0. Axis high bytes (0x05, 0x07, 0x09) carry sample bits 12..7 in bits 5..0, and bits 7..6 read 0. Temperature bits 7..0 are at 0x0C and bits 15..8 at 0x0D.
- R5: A read of a high byte captures the current low byte of the same channel into a shadow. A later read of that low byte returns the shadow, even if the input has changed since.
- R6: The interrupt status at 0x10 holds saturation in bit 6, start-up self-test failure in bit 5 and continuous self-test failure in bit 4. Each bit stays set after its cause ends. A read returns the value before clearing and then clears all three bits.
- R7: If a flag's cause is active in the same cycle as the acknowledging read, the flag is still set afterwards.
- R8: st_flag_o is the OR of the start-up and continuous self-test flags and the live checksum-error input. sat_flag_o follows the saturation flag.
- R9: Writing 0x0C, 0x05 and 0x0F in order to 0x03 raises sw_rst_o for exactly one cycle. It also returns control, the shadows and the interrupt flags to their power-on values. The ID register keeps its value.
- R10: A write to 0x03 that breaks the order returns the key detector to idle, but a byte of 0x0C starts a new sequence. Writes to other addresses between key bytes do not disturb the detector.
- R11: The status register at 0x02 shows the live test-mode input in bit 2, the live checksum-error input in bit 1 and a frame-error flag in bit 0. The frame-error flag sets on frame_bad and clears on frame_good. Bits 7..3 read 0.
- R12: Reads of unmapped addresses and of the key address 0x03 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Register address |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte for the current address |
| acc_x | input | AXW | X-axis sample |
| acc_y | input | AXW | Y-axis sample |
| acc_z | input | AXW | Z-axis sample |
| temp_in | input | TW | Temperature sample |
| sat_evt | input | 1 | Saturation cause |
| stst_fail | input | 1 | Start-up self-test failure cause |
| cstest_fail | input | 1 | Continuous self-test failure cause |
| csum_err | input | 1 | Live checksum error |
| atest_on | input | 1 | Live analog test-mode indication |
| frame_bad | input | 1 | Malformed frame seen |
| frame_good | input | 1 | Well-formed frame seen |
| ctrl_o | output | 8 | Control register contents |
| st_flag_o | output | 1 | Summary self-test flag for the frame |
| sat_flag_o | output | 1 | Saturation flag for the frame |
| sw_rst_o | output | 1 | One-cycle software reset pulse |

## Verification
The checker watches the following rules on every cycle. A cause sets its sticky flag on the next edge. A flag holds until an acknowledge or a reset. The reset pulse lasts one cycle and leaves control at its power-on value. A checksum error always raises the summary flag. A frame error latches. An unmapped read returns zero. Other behaviours span several accesses and only the bench scenarios can show them: high-before-low coherence under changing inputs, the ordering and restart rules of the reset key, the survival of a flag whose cause meets the acknowledge, and the ID surviving a software reset.

// File: rtl/sens_regbank_pkg.sv
package sens_regbank_pkg;
   typedef enum logic [1:0] {KEY_IDLE = 2'd0, KEY_ONE = 2'd1, KEY_TWO = 2'd2} key_st_e;

   localparam logic [7:0] KEY_B0 = 8'h0C;
   localparam logic [7:0] KEY_B1 = 8'h05;
   localparam logic [7:0] KEY_B2 = 8'h0F;

   localparam logic [7:0] A_REV  = 8'h00;
   localparam logic [7:0] A_CTRL = 8'h01;
   localparam logic [7:0] A_STAT = 8'h02;
   localparam logic [7:0] A_KEY  = 8'h03;
   localparam logic [7:0] A_XL   = 8'h04;
   localparam logic [7:0] A_XM   = 8'h05;
   localparam logic [7:0] A_YL   = 8'h06;
   localparam logic [7:0] A_YM   = 8'h07;
   localparam logic [7:0] A_ZL   = 8'h08;
   localparam logic [7:0] A_ZM   = 8'h09;
   localparam logic [7:0] A_TL   = 8'h0C;
   localparam logic [7:0] A_TM   = 8'h0D;
   localparam logic [7:0] A_INT  = 8'h10;
   localparam logic [7:0] A_ID   = 8'h1B;

   localparam int unsigned NFLAG   = 3;
   localparam int unsigned FL_STC  = 0;
   localparam int unsigned FL_STS  = 1;
   localparam int unsigned FL_SAT  = 2;
   localparam int unsigned NCHAN   = 4;
   localparam int unsigned LSB_AXB = 7;
endpackage

// File: rtl/sens_key_detect.sv
module sens_key_detect
   import sens_regbank_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_key,
   input  logic [7:0] wdata,
   output logic       key_hit
);
   key_st_e st_q, st_nxt;

   always_comb begin
      key_hit = 1'b0;
      st_nxt  = st_q;
      if (wr_key) begin
         if (st_q == KEY_TWO && wdata == KEY_B2) begin
            key_hit = 1'b1;
            st_nxt  = KEY_IDLE;
         end else if (st_q == KEY_ONE && wdata == KEY_B1) begin
            st_nxt = KEY_TWO;
         end else if (wdata == KEY_B0) begin
            st_nxt = KEY_ONE;
         end else begin
            st_nxt = KEY_IDLE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= KEY_IDLE;
      else        st_q <= st_nxt;
   end
endmodule

// File: rtl/sens_sticky_flags.sv
module sens_sticky_flags #(
   parameter int unsigned N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_all,
   input  logic         ack,
   input  logic [N-1:0] cause,
   output logic [N-1:0] flag
);
   if (N < 1) begin : g_bad_n
      $error("sens_sticky_flags: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        flag[i] <= 1'b0;
         else if (clr_all)  flag[i] <= 1'b0;
         else if (cause[i]) flag[i] <= 1'b1;
         else if (ack)      flag[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/sens_shadow.sv
module sens_shadow #(
   parameter int unsigned NCH = 4,
   parameter int unsigned W   = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic [NCH-1:0] cap,
   input  logic [NCH*W-1:0] din,
   output logic [NCH*W-1:0] dout
);
   if (NCH < 1 || W < 1) begin : g_bad_cfg
      $error("sens_shadow: NCH and W must be positive");
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      dout[c*W +: W] <= '0;
         else if (clr)    dout[c*W +: W] <= '0;
         else if (cap[c]) dout[c*W +: W] <= din[c*W +: W];
      end
   end
endmodule

// File: rtl/sens_regbank.sv
module sens_regbank
   import sens_regbank_pkg::*;
#(
   parameter int unsigned AW        = 5,
   parameter int unsigned AXW       = 13,
   parameter int unsigned TW        = 16,
   parameter logic [7:0]  REV_CODE  = 8'h02,
   parameter logic [7:0]  ID_INIT   = 8'h5A,
   parameter logic [7:0]  CTRL_INIT = 8'h00
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           rd_en,
   input  logic           wr_en,
   input  logic [AW-1:0]  addr,
   input  logic [7:0]     wdata,
   output logic [7:0]     rdata,
   input  logic [AXW-1:0] acc_x,
   input  logic [AXW-1:0] acc_y,
   input  logic [AXW-1:0] acc_z,
   input  logic [TW-1:0]  temp_in,
   input  logic           sat_evt,
   input  logic           stst_fail,
   input  logic           cstest_fail,
   input  logic           csum_err,
   input  logic           atest_on,
   input  logic           frame_bad,
   input  logic           frame_good,
   output logic [7:0]     ctrl_o,
   output logic           st_flag_o,
   output logic           sat_flag_o,
   output logic           sw_rst_o
);
   localparam int unsigned AX_HI_W = AXW - LSB_AXB;
   localparam int unsigned T_HI_W  = TW - 8;
   localparam int unsigned NAXIS   = 3;

   if (AW < 5 || AW > 8) begin : g_bad_aw
      $error("sens_regbank: AW must be 5..8");
   end
   if (AXW < 8 || AXW > 14) begin : g_bad_axw
      $error("sens_regbank: AXW must be 8..14");
   end
   if (TW < 9 || TW > 16) begin : g_bad_tw
      $error("sens_regbank: TW must be 9..16");
   end

   logic [7:0] addr_ext;
   assign addr_ext = 8'(addr);

   // axis byte formatting
   logic [AXW-1:0] ax_in  [NAXIS];
   logic [7:0]     ax_lsb [NAXIS];
   logic [7:0]     ax_msb [NAXIS];
   assign ax_in[0] = acc_x;
   assign ax_in[1] = acc_y;
   assign ax_in[2] = acc_z;

   for (genvar a = 0; a < NAXIS; a++) begin : g_axis
      assign ax_lsb[a] = {ax_in[a][LSB_AXB-1:0], 1'b0};
      assign ax_msb[a] = 8'(ax_in[a][AXW-1:LSB_AXB]);
   end

   logic [7:0] t_lsb, t_msb;
   assign t_lsb = temp_in[7:0];
   assign t_msb = 8'(temp_in[TW-1:8]);

   // shadow capture on high-byte reads
   logic [NCHAN-1:0]   cap;
   logic [NCHAN*8-1:0] sh_in, sh_q;
   logic               key_hit;

   assign cap[0] = rd_en && (addr_ext == A_XM);
   assign cap[1] = rd_en && (addr_ext == A_YM);
   assign cap[2] = rd_en && (addr_ext == A_ZM);
   assign cap[3] = rd_en && (addr_ext == A_TM);
   assign sh_in  = {t_lsb, ax_lsb[2], ax_lsb[1], ax_lsb[0]};

   sens_shadow #(.NCH(NCHAN), .W(8)) u_shadow (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (key_hit),
      .cap  (cap),
      .din  (sh_in),
      .dout (sh_q)
   );

   // sticky interrupt flags
   logic [NFLAG-1:0] int_q, int_cause;
   logic             int_ack;
   assign int_cause[FL_SAT] = sat_evt;
   assign int_cause[FL_STS] = stst_fail;
   assign int_cause[FL_STC] = cstest_fail;
   assign int_ack           = rd_en && (addr_ext == A_INT);

   sens_sticky_flags #(.N(NFLAG)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_all(key_hit),
      .ack    (int_ack),
      .cause  (int_cause),
      .flag   (int_q)
   );

   // reset key
   sens_key_detect u_key (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_key (wr_en && (addr_ext == A_KEY)),
      .wdata  (wdata),
      .key_hit(key_hit)
   );

   // writable registers and frame error
   logic [7:0] ctrl_q, id_q;
   logic       ferr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= CTRL_INIT;
         id_q     <= ID_INIT;
         ferr_q   <= 1'b0;
         sw_rst_o <= 1'b0;
      end else begin
         sw_rst_o <= key_hit;
         if (key_hit)                              ctrl_q <= CTRL_INIT;
         else if (wr_en && addr_ext == A_CTRL)     ctrl_q <= wdata;
         if (wr_en && addr_ext == A_ID)            id_q   <= wdata;
         if (frame_bad)                            ferr_q <= 1'b1;
         else if (frame_good)                      ferr_q <= 1'b0;
      end
   end

   // read multiplexer
   always_comb begin
      unique case (addr_ext)
         A_REV:   rdata = REV_CODE;
         A_CTRL:  rdata = ctrl_q;
         A_STAT:  rdata = {5'b0, atest_on, csum_err, ferr_q};
         A_XL:    rdata = sh_q[0*8 +: 8];
         A_XM:    rdata = ax_msb[0];
         A_YL:    rdata = sh_q[1*8 +: 8];
         A_YM:    rdata = ax_msb[1];
         A_ZL:    rdata = sh_q[2*8 +: 8];
         A_ZM:    rdata = ax_msb[2];
         A_TL:    rdata = sh_q[3*8 +: 8];
         A_TM:    rdata = t_msb;
         A_INT:   rdata = {1'b0, int_q[FL_SAT], int_q[FL_STS], int_q[FL_STC], 4'b0};
         A_ID:    rdata = id_q;
         default: rdata = 8'h00;
      endcase
   end

   assign ctrl_o     = ctrl_q;
   assign sat_flag_o = int_q[FL_SAT];
   assign st_flag_o  = int_q[FL_STS] | int_q[FL_STC] | csum_err;
endmodule

// File: rtl/sens_regbank_chk.sv
module sens_regbank_chk #(
   parameter int unsigned AW        = 5,
   parameter logic [7:0]  CTRL_INIT = 8'h00
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rd_en,
   input logic [AW-1:0] addr,
   input logic [7:0]    rdata,
   input logic          sat_evt,
   input logic          csum_err,
   input logic          frame_bad,
   input logic          key_hit,
   input logic          ferr_q,
   input logic          sat_flag_o,
   input logic          st_flag_o,
   input logic          sw_rst_o,
   input logic [7:0]    ctrl_o
);
   logic [7:0] a8;
   assign a8 = 8'(addr);

   assert_sat_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_evt && !key_hit) |=> sat_flag_o);

   assert_sat_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_flag_o && !key_hit && !(rd_en && a8 == 8'h10)) |=> sat_flag_o);

   assert_rst_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sw_rst_o |=> !sw_rst_o);

   assert_rst_ctrl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sw_rst_o |-> (ctrl_o == CTRL_INIT));

   assert_csum_summary_R8: assert property (@(posedge clk) disable iff (!rst_n)
      csum_err |-> st_flag_o);

   assert_ferr_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
      frame_bad |=> ferr_q);

   assert_unmapped_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (a8 == 8'h1F || a8 == 8'h03) |-> (rdata == 8'h00));
endmodule

bind sens_regbank sens_regbank_chk #(.AW(AW), .CTRL_INIT(CTRL_INIT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_en     (rd_en),
   .addr      (addr),
   .rdata     (rdata),
   .sat_evt   (sat_evt),
   .csum_err  (csum_err),
   .frame_bad (frame_bad),
   .key_hit   (key_hit),
   .ferr_q    (ferr_q),
   .sat_flag_o(sat_flag_o),
   .st_flag_o (st_flag_o),
   .sw_rst_o  (sw_rst_o),
   .ctrl_o    (ctrl_o)
);

// File: tb/sens_regbank_tb.sv
module sens_regbank_tb;
   localparam logic [7:0] REV = 8'h02;
   localparam logic [7:0] IDI = 8'h5A;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_en = 1'b0, wr_en = 1'b0;
   logic [4:0]  addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic [12:0] acc_x = '0, acc_y = '0, acc_z = '0;
   logic [15:0] temp_in = '0;
   logic sat_evt = 0, stst_fail = 0, cstest_fail = 0, csum_err = 0;
   logic atest_on = 0, frame_bad = 0, frame_good = 0;
   logic [7:0] ctrl_o;
   logic st_flag_o, sat_flag_o, sw_rst_o;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   sens_regbank u_dut (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .acc_x(acc_x), .acc_y(acc_y), .acc_z(acc_z),
      .temp_in(temp_in), .sat_evt(sat_evt), .stst_fail(stst_fail),
      .cstest_fail(cstest_fail), .csum_err(csum_err), .atest_on(atest_on),
      .frame_bad(frame_bad), .frame_good(frame_good), .ctrl_o(ctrl_o),
      .st_flag_o(st_flag_o), .sat_flag_o(sat_flag_o), .sw_rst_o(sw_rst_o)
   );

   function automatic logic [7:0] f_lsb(input logic [12:0] v);
      return {v[6:0], 1'b0};
   endfunction
   function automatic logic [7:0] f_msb(input logic [12:0] v);
      return {2'b00, v[12:7]};
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a[4:0]; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a[4:0]; rd_en = 1'b1;
      #2 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic rdchk(input string tag, input logic [7:0] a, input logic [7:0] exp);
      logic [7:0] d;
      rd(a, d);
      chk(tag, d, exp);
   endtask

   task automatic key_seq(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
      wr(8'h03, b0); wr(8'h03, b1); wr(8'h03, b2);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [12:0] ox, nx;
      logic [15:0] ot;
      int unsigned seed;
      seed = $urandom(32'd2024);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values
      rdchk("R1 rev", 8'h00, REV);
      rdchk("R1 id", 8'h1B, IDI);
      rdchk("R1 ctrl", 8'h01, 8'h00);
      rdchk("R1 int", 8'h10, 8'h00);

      // R2 writable registers
      wr(8'h01, 8'h3C); rdchk("R2 ctrl", 8'h01, 8'h3C);
      chk("R2 ctrl_o", ctrl_o, 8'h3C);
      wr(8'h1B, 8'hA5); rdchk("R2 id", 8'h1B, 8'hA5);

      // R3 read-only writes ignored
      wr(8'h00, 8'hFF); rdchk("R3 rev", 8'h00, REV);
      wr(8'h02, 8'hFF); rdchk("R3 stat", 8'h02, 8'h00);
      wr(8'h10, 8'hFF); rdchk("R3 int", 8'h10, 8'h00);
      acc_y = 13'h0ABC;
      rd(8'h07, ox[7:0]);
      wr(8'h06, 8'hFF); rdchk("R3 ylsb", 8'h06, f_lsb(13'h0ABC));

      // R4 R5 random coherence, directed corners first
      for (int i = 0; i < 40; i++) begin
         if (i == 0) ox = 13'h1FFF;
         else if (i == 1) ox = 13'h1000;
         else ox = 13'($urandom);
         nx = 13'($urandom);
         case (i % 3)
            0: begin acc_x = ox; rdchk("R4 xmsb", 8'h05, f_msb(ox)); acc_x = nx;
                     rdchk("R5 xlsb", 8'h04, f_lsb(ox)); end
            1: begin acc_y = ox; rdchk("R4 ymsb", 8'h07, f_msb(ox)); acc_y = nx;
                     rdchk("R5 ylsb", 8'h06, f_lsb(ox)); end
            default: begin acc_z = ox; rdchk("R4 zmsb", 8'h09, f_msb(ox)); acc_z = nx;
                     rdchk("R5 zlsb", 8'h08, f_lsb(ox)); end
         endcase
      end
      for (int i = 0; i < 8; i++) begin
         ot = 16'($urandom);
         temp_in = ot;
         rdchk("R4 tmsb", 8'h0D, ot[15:8]);
         temp_in = 16'($urandom);
         rdchk("R5 tlsb", 8'h0C, ot[7:0]);
      end

      // R6 R8 sticky saturation
      @(negedge clk); sat_evt = 1'b1;
      @(negedge clk); sat_evt = 1'b0;
      @(negedge clk);
      chk("R8 sat_flag", {7'b0, sat_flag_o}, 8'h01);
      rdchk("R6 int sat", 8'h10, 8'h40);
      rdchk("R6 int cleared", 8'h10, 8'h00);
      @(negedge clk); cstest_fail = 1'b1;
      @(negedge clk); cstest_fail = 1'b0;
      @(negedge clk);
      chk("R8 st_flag stc", {7'b0, st_flag_o}, 8'h01);
      rdchk("R6 int stc", 8'h10, 8'h10);
      chk("R8 st_flag clear", {7'b0, st_flag_o}, 8'h00);

      // R7 cause coincides with acknowledge
      @(negedge clk); stst_fail = 1'b1;
      rdchk("R7 first", 8'h10, 8'h20);
      stst_fail = 1'b0;
      rdchk("R7 survives", 8'h10, 8'h20);
      rdchk("R7 then clear", 8'h10, 8'h00);

      // R8 checksum feeds summary
      csum_err = 1'b1; #1;
      chk("R8 csum st", {7'b0, st_flag_o}, 8'h01);

      // R11 status register
      atest_on = 1'b1;
      rdchk("R11 live", 8'h02, 8'h06);
      csum_err = 1'b0; atest_on = 1'b0;
      @(negedge clk); frame_bad = 1'b1;
      @(negedge clk); frame_bad = 1'b0;
      rdchk("R11 ferr set", 8'h02, 8'h01);
      rdchk("R11 ferr held", 8'h02, 8'h01);
      @(negedge clk); frame_good = 1'b1;
      @(negedge clk); frame_good = 1'b0;
      rdchk("R11 ferr clear", 8'h02, 8'h00);

      // R9 software reset
      wr(8'h01, 8'h77);
      acc_x = 13'h0155; rdchk("R9 prep", 8'h05, f_msb(13'h0155));
      @(negedge clk); sat_evt = 1'b1;
      @(negedge clk); sat_evt = 1'b0;
      key_seq(8'h0C, 8'h05, 8'h0F);
      chk("R9 pulse", {7'b0, sw_rst_o}, 8'h01);
      @(negedge clk);
      chk("R9 pulse end", {7'b0, sw_rst_o}, 8'h00);
      rdchk("R9 ctrl", 8'h01, 8'h00);
      rdchk("R9 shadow", 8'h04, 8'h00);
      rdchk("R9 int", 8'h10, 8'h00);
      rdchk("R9 id kept", 8'h1B, 8'hA5);

      // R10 key order rules
      wr(8'h01, 8'h11);
      wr(8'h03, 8'h0C); key_seq(8'h0C, 8'h05, 8'h0F);
      chk("R10 restart", {7'b0, sw_rst_o}, 8'h01);
      wr(8'h01, 8'h22);
      key_seq(8'h0C, 8'h05, 8'hAA); wr(8'h03, 8'h0F);
      chk("R10 broken", {7'b0, sw_rst_o}, 8'h00);
      rdchk("R10 ctrl kept", 8'h01, 8'h22);
      wr(8'h03, 8'h0C); wr(8'h03, 8'h05); wr(8'h01, 8'h33); wr(8'h03, 8'h0F);
      chk("R10 other addr", {7'b0, sw_rst_o}, 8'h01);

      // R12 unmapped and key address reads
      rdchk("R12 key", 8'h03, 8'h00);
      rdchk("R12 0a", 8'h0A, 8'h00);
      rdchk("R12 1f", 8'h1F, 8'h00);
      rdchk("R12 11", 8'h11, 8'h00);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule